// File: doc/BRIEF.md
# SATA Out-of-Band COM Signal Detector

This block sits on the receive side of a serial link and sorts the out-of-band signalling that the far end sends. One activity input comes from an analog squelch detector and is high while line activity is seen. The block samples that input on its own clock and measures the length of every activity burst and every quiet gap in whole clock cycles. Each length is compared against programmable windows. One window qualifies bursts. Two separate windows qualify gaps: the long gap that belongs to an initialisation or reset request, and the short gap that belongs to a wake request.

Qualifying bursts and gaps are counted. When both counts have reached their programmed thresholds, the block raises a one-clock pulse. The pulse comes out on the init/reset output or on the wake output, depending on the gap type that was accumulated. A link-layer state machine uses these pulses to start speed negotiation or to leave a power-saving state.

Top module: `oob_com_detect`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, both detect outputs are low.
- R2: A burst of N high cycles on `sq_in` counts only if `burst_min <= N <= burst_max`; both limits are inclusive.
- R3: A gap of N low cycles between bursts counts toward an init/reset match only if `init_min <= N <= init_max`. This window takes priority if the two gap windows overlap.
- R4: A gap of N low cycles counts toward a wake match only if `wake_min <= N <= wake_max`.
- R5: A detect pulse is raised at the end of a burst or gap that brings the burst count to at least `burst_need` and the gap count to at least `idle_need`. Both counts saturate at 7.
- R6: A counting gap of the type opposite to the one being accumulated sets the gap count to 1 and the burst count to 0, and switches the accumulated type.
- R7: A burst outside its window, or a gap that fits neither gap window, clears both counts.
- R8: Duration counting saturates at all ones. A gap longer than the larger of `init_max` and `wake_max` clears both counts, however long it lasts, so a very long gap never counts as a short one. Both gap maxima must stay below the saturation value.
- R9: Each detect pulse is high for exactly one clock, and the two outputs are never high together.
- R10: After a pulse both counts restart from zero, so a further pulse needs a full new set of bursts and gaps.
- R11: A pulse appears on the third rising clock edge after the `sq_in` edge that ends the completing segment, two of those edges being the input synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Squelch sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sq_in | input | 1 | Line activity from the squelch detector, high during a burst |
| burst_min | input | CNT_W | Shortest counting burst, in cycles |
| burst_max | input | CNT_W | Longest counting burst, in cycles |
| init_min | input | CNT_W | Shortest init/reset gap, in cycles |
| init_max | input | CNT_W | Longest init/reset gap, in cycles |
| wake_min | input | CNT_W | Shortest wake gap, in cycles |
| wake_max | input | CNT_W | Longest wake gap, in cycles |
| burst_need | input | 3 | Counting bursts needed for a match |
| idle_need | input | 3 | Counting gaps needed for a match |
| det_init | output | 1 | One-clock pulse on an init/reset match |
| det_wake | output | 1 | One-clock pulse on a wake match |

## Verification
A gap can end in the same cycle in which the idle timeout would fire. This happens when the gap length equals the larger gap maximum, and when it is one cycle longer. The bench sweeps gap lengths across both window edges and past that maximum. The result at each step is judged only by which pulse comes out: the gap counts up to the maximum and is cleared from the next cycle on. A second coincidence is a completing burst end together with the clearing of both counts. It is provoked by a long run of valid bursts and gaps, and judged by the exact number of pulses that come out.

// File: rtl/oob_pkg.sv
package oob_pkg;
  localparam int NEED_W = 3;

  typedef enum logic [1:0] {
    GAP_NONE = 2'd0,
    GAP_INIT = 2'd1,
    GAP_WAKE = 2'd2
  } gap_kind_e;
endpackage

// File: rtl/oob_sync.sv
module oob_sync (
  input  logic clk,
  input  logic arst_n,
  input  logic sq_raw,
  output logic srst_n,
  output logic sq_s
);
  logic rst_a, rst_b;
  logic sq_a, sq_b;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_a <= 1'b0;
      rst_b <= 1'b0;
    end else begin
      rst_a <= 1'b1;
      rst_b <= rst_a;
    end
  end

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) begin
      sq_a <= 1'b0;
      sq_b <= 1'b0;
    end else begin
      sq_a <= sq_raw;
      sq_b <= sq_a;
    end
  end

  assign srst_n = rst_b;
  assign sq_s   = sq_b;
endmodule

// File: rtl/oob_span.sv
module oob_span #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             sq_s,
  output logic             seg_end,
  output logic             run_lvl,
  output logic [CNT_W-1:0] run_len
);
  localparam logic [CNT_W-1:0] LEN_SAT = {CNT_W{1'b1}};

  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] len_q, len_d;

  always_comb begin
    seg_end = (sq_s != lvl_q);
    lvl_d   = sq_s;
    if (seg_end)
      len_d = CNT_W'(1);
    else if (len_q == LEN_SAT)
      len_d = len_q;
    else
      len_d = len_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      lvl_q <= 1'b0;
      len_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      len_q <= len_d;
    end
  end

  assign run_lvl = lvl_q;
  assign run_len = len_q;
endmodule

// File: rtl/oob_tally.sv
module oob_tally
  import oob_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              seg_end,
  input  logic              run_lvl,
  input  logic [CNT_W-1:0]  run_len,
  input  logic [CNT_W-1:0]  burst_min,
  input  logic [CNT_W-1:0]  burst_max,
  input  logic [CNT_W-1:0]  init_min,
  input  logic [CNT_W-1:0]  init_max,
  input  logic [CNT_W-1:0]  wake_min,
  input  logic [CNT_W-1:0]  wake_max,
  input  logic [NEED_W-1:0] burst_need,
  input  logic [NEED_W-1:0] idle_need,
  output logic [NEED_W-1:0] bcnt_o,
  output logic [NEED_W-1:0] icnt_o,
  output logic              det_init,
  output logic              det_wake
);
  localparam logic [NEED_W-1:0] NEED_SAT = {NEED_W{1'b1}};

  logic [NEED_W-1:0] bcnt_q, bcnt_d, icnt_q, icnt_d;
  gap_kind_e         kind_q, kind_d, seen;
  logic              di_q, di_d, dw_q, dw_d;
  logic              upd, fire, burst_ok, gap_over;
  logic [CNT_W-1:0]  gap_top;

  always_comb begin
    gap_top  = (init_max > wake_max) ? init_max : wake_max;
    burst_ok = (run_len >= burst_min) && (run_len <= burst_max);
    gap_over = !run_lvl && (run_len > gap_top);
    if ((run_len >= init_min) && (run_len <= init_max))
      seen = GAP_INIT;
    else if ((run_len >= wake_min) && (run_len <= wake_max))
      seen = GAP_WAKE;
    else
      seen = GAP_NONE;

    bcnt_d = bcnt_q;
    icnt_d = icnt_q;
    kind_d = kind_q;
    if (seg_end && run_lvl) begin
      if (burst_ok) begin
        if (bcnt_q != NEED_SAT) bcnt_d = bcnt_q + NEED_W'(1);
      end else begin
        bcnt_d = '0;
        icnt_d = '0;
        kind_d = GAP_NONE;
      end
    end else if (seg_end) begin
      if (seen == GAP_NONE) begin
        bcnt_d = '0;
        icnt_d = '0;
        kind_d = GAP_NONE;
      end else if ((kind_q != GAP_NONE) && (kind_q != seen)) begin
        bcnt_d = '0;
        icnt_d = NEED_W'(1);
        kind_d = seen;
      end else begin
        kind_d = seen;
        if (icnt_q != NEED_SAT) icnt_d = icnt_q + NEED_W'(1);
      end
    end else if (gap_over) begin
      bcnt_d = '0;
      icnt_d = '0;
      kind_d = GAP_NONE;
    end

    fire = seg_end && (kind_d != GAP_NONE) &&
           (bcnt_d >= burst_need) && (icnt_d >= idle_need);
    di_d = fire && (kind_d == GAP_INIT);
    dw_d = fire && (kind_d == GAP_WAKE);
    if (fire) begin
      bcnt_d = '0;
      icnt_d = '0;
      kind_d = GAP_NONE;
    end
    upd = seg_end || gap_over;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bcnt_q <= '0;
      icnt_q <= '0;
      kind_q <= GAP_NONE;
    end else if (upd) begin
      bcnt_q <= bcnt_d;
      icnt_q <= icnt_d;
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      di_q <= 1'b0;
      dw_q <= 1'b0;
    end else begin
      di_q <= di_d;
      dw_q <= dw_d;
    end
  end

  assign bcnt_o   = bcnt_q;
  assign icnt_o   = icnt_q;
  assign det_init = di_q;
  assign det_wake = dw_q;
endmodule

// File: rtl/oob_com_detect.sv
module oob_com_detect
  import oob_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sq_in,
  input  logic [CNT_W-1:0]  burst_min,
  input  logic [CNT_W-1:0]  burst_max,
  input  logic [CNT_W-1:0]  init_min,
  input  logic [CNT_W-1:0]  init_max,
  input  logic [CNT_W-1:0]  wake_min,
  input  logic [CNT_W-1:0]  wake_max,
  input  logic [NEED_W-1:0] burst_need,
  input  logic [NEED_W-1:0] idle_need,
  output logic              det_init,
  output logic              det_wake
);
  logic              srst_n, sq_s, seg_end, run_lvl;
  logic [CNT_W-1:0]  run_len;
  logic [NEED_W-1:0] b_cnt, i_cnt;

  oob_sync u_sync (
    .clk(clk), .arst_n(rst_n), .sq_raw(sq_in), .srst_n(srst_n), .sq_s(sq_s)
  );

  oob_span #(.CNT_W(CNT_W)) u_span (
    .clk(clk), .srst_n(srst_n), .sq_s(sq_s),
    .seg_end(seg_end), .run_lvl(run_lvl), .run_len(run_len)
  );

  oob_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .srst_n(srst_n), .seg_end(seg_end), .run_lvl(run_lvl),
    .run_len(run_len), .burst_min(burst_min), .burst_max(burst_max),
    .init_min(init_min), .init_max(init_max), .wake_min(wake_min),
    .wake_max(wake_max), .burst_need(burst_need), .idle_need(idle_need),
    .bcnt_o(b_cnt), .icnt_o(i_cnt), .det_init(det_init), .det_wake(det_wake)
  );
endmodule

// File: rtl/oob_com_chk.sv
module oob_com_chk #(
  parameter int CNT_W = 8,
  parameter int NW    = 3
) (
  input logic             clk,
  input logic             srst_n,
  input logic             det_init,
  input logic             det_wake,
  input logic             seg_end,
  input logic [CNT_W-1:0] run_len,
  input logic [NW-1:0]    b_cnt,
  input logic [NW-1:0]    i_cnt
);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !(det_init && det_wake));

  assert_init_one_clock_R9: assert property (@(posedge clk) disable iff (!srst_n)
    det_init |=> !det_init);

  assert_wake_one_clock_R9: assert property (@(posedge clk) disable iff (!srst_n)
    det_wake |=> !det_wake);

  assert_counts_cleared_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (det_init || det_wake) |-> (b_cnt == '0 && i_cnt == '0));

  assert_pulse_after_edge_R11: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(det_init) |-> $past(seg_end));

  assert_len_no_wrap_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (run_len != CNT_W'(1)) |-> (run_len >= $past(run_len)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !srst_n |-> (!det_init && !det_wake));
endmodule

bind oob_com_detect oob_com_chk #(.CNT_W(CNT_W), .NW(oob_pkg::NEED_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .det_init(det_init), .det_wake(det_wake),
  .seg_end(seg_end), .run_len(run_len), .b_cnt(b_cnt), .i_cnt(i_cnt)
);

// File: tb/sim_oob_com_detect.sv
module sim_oob_com_detect;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sq_in = 1'b0;
  logic [W-1:0] burst_min = W'(4), burst_max = W'(8);
  logic [W-1:0] init_min = W'(20), init_max = W'(30);
  logic [W-1:0] wake_min = W'(10), wake_max = W'(15);
  logic [2:0] burst_need = 3'd3, idle_need = 3'd2;
  logic det_init, det_wake;

  int errors = 0, checks = 0;
  int n_init = 0, n_wake = 0, base_i = 0, base_w = 0;
  int cyc = 0, drop_cyc = 0, pulse_cyc = -1;
  bit width_bad = 0, both_bad = 0;
  logic prev_i = 1'b0, prev_w = 1'b0;

  always #2.5 clk = ~clk;

  oob_com_detect #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sq_in(sq_in),
    .burst_min(burst_min), .burst_max(burst_max),
    .init_min(init_min), .init_max(init_max),
    .wake_min(wake_min), .wake_max(wake_max),
    .burst_need(burst_need), .idle_need(idle_need),
    .det_init(det_init), .det_wake(det_wake)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (det_init) n_init <= n_init + 1;
      if (det_wake) n_wake <= n_wake + 1;
      if ((det_init || det_wake) && !(prev_i || prev_w)) pulse_cyc <= cyc;
      if ((det_init && prev_i) || (det_wake && prev_w)) width_bad <= 1'b1;
      if (det_init && det_wake) both_bad <= 1'b1;
      prev_i <= det_init;
      prev_w <= det_wake;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic burst(int n);
    sq_in = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(int n);
    sq_in = 1'b0;
    drop_cyc = cyc;
    repeat (n) @(negedge clk);
  endtask

  task automatic start_seq();
    idle(70);
    base_i = n_init;
    base_w = n_wake;
  endtask

  task automatic end_seq(string req, int ei, int ew);
    idle(70);
    check({req, " init pulses"}, n_init - base_i, ei);
    check({req, " wake pulses"}, n_wake - base_w, ew);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 det_init in reset", int'(det_init), 0);
    check("R1 det_wake in reset", int'(det_wake), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 det_init after release", int'(det_init), 0);
    check("R1 det_wake after release", int'(det_wake), 0);

    // R2: burst length sweep, window 4..8
    for (int len = 1; len <= 12; len++) begin
      start_seq();
      burst(len); idle(25); burst(len); idle(25); burst(len);
      end_seq("R2", (len >= 4 && len <= 8) ? 1 : 0, 0);
    end

    // R3 / R4 / R8: gap sweep across both windows and past the larger maximum
    for (int gap = 5; gap <= 40; gap++) begin
      start_seq();
      burst(6); idle(gap); burst(6); idle(gap); burst(6);
      end_seq("R3 R4 R8", (gap >= 20 && gap <= 30) ? 1 : 0,
              (gap >= 10 && gap <= 15) ? 1 : 0);
    end

    // R11: latency from the falling input to the pulse
    start_seq();
    burst(6); idle(12); burst(6); idle(12); burst(6);
    idle(10);
    check("R11 pulse cycle", pulse_cyc - drop_cyc, 3);
    end_seq("R11", 0, 1);

    // R5: thresholds
    burst_need = 3'd2; idle_need = 3'd1;
    start_seq();
    burst(6); idle(25); burst(6);
    end_seq("R5 need 2/1", 1, 0);
    burst_need = 3'd3; idle_need = 3'd3;
    start_seq();
    burst(6); idle(25); burst(6); idle(25); burst(6);
    end_seq("R5 idle short", 0, 0);
    burst_need = 3'd3; idle_need = 3'd2;

    // R6: switching gap type restarts
    start_seq();
    burst(6); idle(25); burst(6); idle(12); burst(6);
    end_seq("R6", 0, 0);

    // R7: rejected burst clears
    start_seq();
    burst(6); idle(25); burst(2); idle(25); burst(6); idle(25); burst(6);
    end_seq("R7", 0, 0);

    // R8: long gap of 86 cycles must not alias to a short one
    burst_need = 3'd2; idle_need = 3'd2;
    start_seq();
    burst(6); idle(86); burst(6); idle(25); burst(6);
    end_seq("R8", 0, 0);
    burst_need = 3'd3;

    // R10: six bursts and five gaps give exactly two pulses
    start_seq();
    for (int k = 0; k < 5; k++) begin
      burst(6); idle(25);
    end
    burst(6);
    end_seq("R10", 2, 0);

    check("R9 pulse width", int'(width_bad), 0);
    check("R9 exclusive", int'(both_bad), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule